// File: doc/BRIEF.md
# SIMD Compare-Against-Zero Lane Unit

This block takes one vector operand and tests every lane against zero under a selected condition. Each lane of the result is filled with ones where the condition holds and with zeros where it does not. A downstream select or blend can use the result directly as a lane mask. Lanes are signed integers of 8, 16 or 32 bits, or 32-bit single-precision floats. The operand is either a full 128-bit quad vector or a 64-bit half vector.

Alongside the data, the unit receives the destination and source register indices, so that it can reject encodings that are illegal in quad mode. An illegal element size, an illegal size for float mode, and an unknown condition code are rejected in the same way. A rejected request raises an undefined-encoding flag and yields an all-zero mask. The result and the flag are registered, so they appear one clock after the request.

For float lanes, less-or-equal and less-than are formed by swapping the operands of the greater-or-equal and greater-than comparator, so zero becomes the left-hand operand. Float lanes follow IEEE ordering: a NaN never satisfies any condition, and both signed zeros equal zero.

Top module: `cmpz_unit`

## Requirements
- R1: Outputs are registered. A request presented before a rising edge appears on `mask_q` and `undef_q` after that edge. While `rst` is high at an edge, both outputs are cleared to zero.
- R2: Size code 2'b11 raises `undef_q` for every condition. Whenever `undef_q` is 1, `mask_q` is all zeros.
- R3: With `float_sel`=1, any size code other than 2'b10 raises `undef_q`.
- R4: With `quad_sel`=1, an odd `dst_reg` or an odd `src_reg` (bit 0 set) raises `undef_q`. With `quad_sel`=0, register parity is ignored.
- R5: Condition codes are EQ=0, GE=1, GT=2, LE=3 and LT=4. Codes 5 to 7 raise `undef_q`.
- R6: Integer lane width is 8 shifted left by the size code: 2'b00 gives 8 bits, 2'b01 gives 16 bits and 2'b10 gives 32 bits. Lane i occupies bits [i*W +: W]. The comparison is signed, so a lane whose top bit is set is below zero.
- R7: A lane whose condition holds is all ones across the lane width. A lane whose condition fails is all zeros.
- R8: Float lanes are IEEE single precision. A NaN (exponent 8'hFF with a nonzero mantissa) is false for every condition. +0 and -0 both equal zero. Infinities order normally. LE and LT mean zero >= x and zero > x.
- R9: With `quad_sel`=0, only the low 64 bits are evaluated and the upper 64 bits of `mask_q` are zero. With `quad_sel`=1, all 128 bits are evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | 128 | Vector to compare against zero |
| size_code | input | 2 | Element size code |
| float_sel | input | 1 | 1 = single-precision float lanes |
| quad_sel | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| cond | input | 3 | Condition code |
| dst_reg | input | 5 | Destination register index |
| src_reg | input | 5 | Source register index |
| mask_q | output | 128 | Registered lane mask |
| undef_q | output | 1 | Registered undefined-encoding flag |

## Verification
Rejection and comparison share one cycle. A request can be illegal and still carry lanes that would otherwise compare true, so the bench sends such requests with all-zero operands under EQ. Every lane would be all ones if the rejection were lost, and the check expects the flag set and an all-zero mask. Half-width masking can also meet odd register indices in the same cycle. That case is provoked with odd indices in 64-bit mode and must give an unflagged result with a zero upper half.

// File: rtl/cmpz_pkg.sv
package cmpz_pkg;
  typedef enum logic [2:0] {
    CMP_EQ = 3'd0,
    CMP_GE = 3'd1,
    CMP_GT = 3'd2,
    CMP_LE = 3'd3,
    CMP_LT = 3'd4
  } cmp_cond_e;

  localparam logic [1:0] SZ_FP32 = 2'b10;
  localparam logic [1:0] SZ_BAD  = 2'b11;

  function automatic logic cond_known(input logic [2:0] c);
    return c <= 3'd4;
  endfunction
endpackage

// File: rtl/cmpz_int_lane.sv
module cmpz_int_lane
  import cmpz_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [2:0]   cond,
  output logic         hit
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (x == '0);
  assign is_neg  = x[W-1];

  always_comb begin
    unique case (cond)
      CMP_EQ:  hit = is_zero;
      CMP_GE:  hit = !is_neg;
      CMP_GT:  hit = !is_neg && !is_zero;
      CMP_LE:  hit = is_neg || is_zero;
      CMP_LT:  hit = is_neg;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmpz_fp_lane.sv
module cmpz_fp_lane
  import cmpz_pkg::*;
(
  input  logic [31:0] x,
  input  logic [2:0]  cond,
  output logic        hit
);
  logic        x_nan;
  logic        swap;
  logic [31:0] lhs;
  logic [31:0] rhs;
  logic        gt_ab;
  logic        eq_ab;

  function automatic logic f_gt(input logic [31:0] a, input logic [31:0] b);
    logic az, bz;
    az = (a[30:0] == '0);
    bz = (b[30:0] == '0);
    if (az && bz)           return 1'b0;
    else if (a[31] != b[31]) return !a[31];
    else if (!a[31])        return a[30:0] > b[30:0];
    else                    return a[30:0] < b[30:0];
  endfunction

  function automatic logic f_eq(input logic [31:0] a, input logic [31:0] b);
    return ((a[30:0] == '0) && (b[30:0] == '0)) || (a == b);
  endfunction

  assign x_nan = (x[30:23] == 8'hFF) && (x[22:0] != '0);
  // LE/LT reuse the GE/GT comparator with zero moved to the left side
  assign swap  = (cond == CMP_LE) || (cond == CMP_LT);
  assign lhs   = swap ? 32'h0 : x;
  assign rhs   = swap ? x : 32'h0;
  assign gt_ab = f_gt(lhs, rhs);
  assign eq_ab = f_eq(lhs, rhs);

  always_comb begin
    unique case (cond)
      CMP_EQ:         hit = !x_nan && eq_ab;
      CMP_GE, CMP_LE: hit = !x_nan && (gt_ab || eq_ab);
      CMP_GT, CMP_LT: hit = !x_nan && gt_ab;
      default:        hit = 1'b0;
    endcase
  end

  always_comb begin
    if (x_nan) p_nan_false_r8: assert (!hit);
  end
endmodule

// File: rtl/cmpz_decode.sv
module cmpz_decode
  import cmpz_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [1:0]       size_code,
  input  logic             float_sel,
  input  logic             quad_sel,
  input  logic [2:0]       cond,
  input  logic [IDX_W-1:0] dst_reg,
  input  logic [IDX_W-1:0] src_reg,
  output logic             undef
);
  logic bad_size, bad_fp, bad_pair, bad_cond;

  assign bad_size = (size_code == SZ_BAD);
  assign bad_fp   = float_sel && (size_code != SZ_FP32);
  assign bad_pair = quad_sel && (dst_reg[0] || src_reg[0]);
  assign bad_cond = !cond_known(cond);
  assign undef    = bad_size || bad_fp || bad_pair || bad_cond;
endmodule

// File: rtl/cmpz_unit.sv
module cmpz_unit
  import cmpz_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] operand,
  input  logic [1:0]       size_code,
  input  logic             float_sel,
  input  logic             quad_sel,
  input  logic [2:0]       cond,
  input  logic [IDX_W-1:0] dst_reg,
  input  logic [IDX_W-1:0] src_reg,
  output logic [VEC_W-1:0] mask_q,
  output logic             undef_q
);
  localparam int HALF_W = VEC_W / 2;
  localparam int N8     = VEC_W / 8;
  localparam int N16    = VEC_W / 16;
  localparam int N32    = VEC_W / 32;

  logic [VEC_W-1:0] m8, m16, m32, mfp;
  logic [VEC_W-1:0] sel_mask, next_mask;
  logic             undef_c;

  cmpz_decode #(.IDX_W(IDX_W)) u_dec (
    .size_code(size_code), .float_sel(float_sel), .quad_sel(quad_sel),
    .cond(cond), .dst_reg(dst_reg), .src_reg(src_reg), .undef(undef_c)
  );

  for (genvar i = 0; i < N8; i++) begin : g_b
    logic h;
    cmpz_int_lane #(.W(8)) u_l (.x(operand[i*8 +: 8]), .cond(cond), .hit(h));
    assign m8[i*8 +: 8] = {8{h}};
  end

  for (genvar i = 0; i < N16; i++) begin : g_h
    logic h;
    cmpz_int_lane #(.W(16)) u_l (.x(operand[i*16 +: 16]), .cond(cond), .hit(h));
    assign m16[i*16 +: 16] = {16{h}};
  end

  for (genvar i = 0; i < N32; i++) begin : g_w
    logic hi, hf;
    cmpz_int_lane #(.W(32)) u_l (.x(operand[i*32 +: 32]), .cond(cond), .hit(hi));
    cmpz_fp_lane u_f (.x(operand[i*32 +: 32]), .cond(cond), .hit(hf));
    assign m32[i*32 +: 32] = {32{hi}};
    assign mfp[i*32 +: 32] = {32{hf}};
  end

  always_comb begin
    unique case (size_code)
      2'b00:   sel_mask = m8;
      2'b01:   sel_mask = m16;
      2'b10:   sel_mask = float_sel ? mfp : m32;
      default: sel_mask = '0;
    endcase
    next_mask = sel_mask;
    if (!quad_sel) next_mask[VEC_W-1:HALF_W] = '0;
    if (undef_c)   next_mask = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      undef_q <= 1'b0;
    end else begin
      mask_q  <= next_mask;
      undef_q <= undef_c;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (mask_q == '0 && !undef_q));
  p_size3_undef_r2: assert property (@(posedge clk) disable iff (rst)
    (size_code == SZ_BAD) |=> undef_q);
  p_undef_zero_r2: assert property (@(posedge clk) disable iff (rst)
    undef_q |-> (mask_q == '0));
  p_fp_size_r3: assert property (@(posedge clk) disable iff (rst)
    (float_sel && size_code != SZ_FP32) |=> undef_q);
  p_quad_odd_r4: assert property (@(posedge clk) disable iff (rst)
    (quad_sel && (dst_reg[0] || src_reg[0])) |=> undef_q);
  p_bad_cond_r5: assert property (@(posedge clk) disable iff (rst)
    (cond > 3'd4) |=> undef_q);
  p_half_upper_r9: assert property (@(posedge clk) disable iff (rst)
    !quad_sel |=> (mask_q[VEC_W-1:HALF_W] == '0));
endmodule

// File: tb/cmpz_unit_bench.sv
module cmpz_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] operand = '0;
  logic [1:0]   size_code = '0;
  logic         float_sel = 1'b0;
  logic         quad_sel = 1'b1;
  logic [2:0]   cond = '0;
  logic [4:0]   dst_reg = '0;
  logic [4:0]   src_reg = '0;
  logic [127:0] mask_q;
  logic         undef_q;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpz_unit u_cmpz_unit (
    .clk(clk), .rst(rst), .operand(operand), .size_code(size_code),
    .float_sel(float_sel), .quad_sel(quad_sel), .cond(cond),
    .dst_reg(dst_reg), .src_reg(src_reg), .mask_q(mask_q), .undef_q(undef_q)
  );

  localparam logic [127:0] VA = 128'h8000_0000_7F80_0000_FFC0_0001_3F80_0000;
  localparam logic [127:0] VB = 128'hBF80_0000_0000_0000_FF80_0000_7FC0_0000;
  localparam logic [127:0] VC = 128'h00FF_7F80_0001_8000_FFFF_0000_1234_8765;
  localparam logic [127:0] VD = 128'h0000_0000_8000_0000_7FFF_FFFF_FFFF_FFFF;

  localparam logic [127:0] T_OP [NT] = '{VC, VC, VC, VC, VD, VD, VA, VA, VA, VB, VB, VC};
  localparam logic [1:0]   T_SZ [NT] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd0};
  localparam logic         T_FL [NT] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0};
  localparam logic         T_Q  [NT] = '{1, 1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 0};
  localparam logic [2:0]   T_CD [NT] = '{3'd0, 3'd2, 3'd1, 3'd3, 3'd4, 3'd2, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd3};

  // Independent reference written from the requirements
  function automatic logic [128:0] ref_model(input logic [127:0] op, input logic [1:0] sz,
      input logic fl, input logic q, input logic [2:0] cd, input logic [4:0] d, input logic [4:0] s);
    logic [127:0] res;
    int w, lanes;
    if (sz == 2'b11 || (fl && sz != 2'b10) || (q && (d[0] || s[0])) || cd > 3'd4)
      return {1'b1, 128'h0};
    res = '0;
    w = 8 << sz;
    lanes = (q ? 128 : 64) / w;
    for (int i = 0; i < lanes; i++) begin
      logic [127:0] sh;
      logic [31:0] v;
      logic neg, zero, nan, hit;
      sh = op >> (i * w);
      v = sh[31:0] & ((w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1));
      if (fl) begin
        nan = (v[30:23] == 8'hFF) && (v[22:0] != 0);
        zero = (v[30:0] == 0);
        neg = v[31];
      end else begin
        nan = 1'b0;
        zero = (v == 0);
        neg = v[w-1];
      end
      case (cd)
        3'd0: hit = zero;
        3'd1: hit = !neg || zero;
        3'd2: hit = !neg && !zero;
        3'd3: hit = neg || zero;
        default: hit = neg && !zero;
      endcase
      if (nan) hit = 1'b0;
      if (hit) res = res | ((((128'h1 << w) - 128'h1)) << (i * w));
    end
    return {1'b0, res};
  endfunction

  task automatic check(input string tag, input logic [128:0] act, input logic [128:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] op, input logic [1:0] sz, input logic fl,
      input logic q, input logic [2:0] cd, input logic [4:0] d, input logic [4:0] s);
    @(negedge clk);
    operand = op; size_code = sz; float_sel = fl; quad_sel = q; cond = cd;
    dst_reg = d; src_reg = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset clears outputs", {undef_q, mask_q}, 129'h0);
    rst = 1'b0;

    for (int t = 0; t < NT; t++) begin
      apply(T_OP[t], T_SZ[t], T_FL[t], T_Q[t], T_CD[t], 5'd2, 5'd4);
      check(T_FL[t] ? "R8 R7 float table" : "R6 R7 integer table", {undef_q, mask_q},
            ref_model(T_OP[t], T_SZ[t], T_FL[t], T_Q[t], T_CD[t], 5'd2, 5'd4));
    end

    // R1: output holds until the next edge
    apply(128'h0, 2'd0, 1'b0, 1'b1, 3'd0, 5'd0, 5'd0);
    check("R1 all-zero EQ", {undef_q, mask_q}, {1'b0, {128{1'b1}}});
    @(negedge clk);
    operand = 128'h0101_0101_0101_0101_0101_0101_0101_0101;
    #1;
    check("R1 output still registered", {undef_q, mask_q}, {1'b0, {128{1'b1}}});
    @(negedge clk);
    check("R1 new value after edge", {undef_q, mask_q}, 129'h0);

    // Rejection collides with an all-true compare
    apply(128'h0, 2'b11, 1'b0, 1'b1, 3'd0, 5'd0, 5'd0);
    check("R2 size 11 undefined, mask zero", {undef_q, mask_q}, {1'b1, 128'h0});
    apply(128'h0, 2'b00, 1'b1, 1'b1, 3'd0, 5'd0, 5'd0);
    check("R3 float with 8-bit size", {undef_q, mask_q}, {1'b1, 128'h0});
    apply(128'h0, 2'b01, 1'b1, 1'b1, 3'd1, 5'd0, 5'd0);
    check("R3 float with 16-bit size", {undef_q, mask_q}, {1'b1, 128'h0});
    apply(128'h0, 2'b10, 1'b0, 1'b1, 3'd0, 5'd3, 5'd0);
    check("R4 quad odd destination", {undef_q, mask_q}, {1'b1, 128'h0});
    apply(128'h0, 2'b10, 1'b0, 1'b1, 3'd0, 5'd0, 5'd7);
    check("R4 quad odd source", {undef_q, mask_q}, {1'b1, 128'h0});
    apply(128'h0, 2'b10, 1'b0, 1'b0, 3'd0, 5'd3, 5'd5);
    check("R4 R9 half mode ignores parity", {undef_q, mask_q},
          {1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF});
    apply(128'h0, 2'b00, 1'b0, 1'b1, 3'd5, 5'd0, 5'd0);
    check("R5 condition 5 undefined", {undef_q, mask_q}, {1'b1, 128'h0});
    apply(128'h0, 2'b00, 1'b0, 1'b1, 3'd7, 5'd0, 5'd0);
    check("R5 condition 7 undefined", {undef_q, mask_q}, {1'b1, 128'h0});

    // R6 signed byte corner: 0x80 is below zero
    apply(128'h0101_0101_0101_0101_0101_0101_0101_0180, 2'b00, 1'b0, 1'b1, 3'd4, 5'd0, 5'd0);
    check("R6 byte -128 LT", {undef_q, mask_q}, {1'b0, 128'hFF});
    apply(128'h0101_0101_0101_0101_0101_0101_0101_0180, 2'b00, 1'b0, 1'b1, 3'd2, 5'd0, 5'd0);
    check("R6 R7 byte GT", {undef_q, mask_q}, {1'b0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FF00});

    // R8 NaN and signed zeros
    apply({32'h7F80_0001, 32'h8000_0000, 32'h0000_0000, 32'h7FC0_0000}, 2'b10, 1'b1, 1'b1, 3'd0, 5'd0, 5'd0);
    check("R8 EQ with NaN and zeros", {undef_q, mask_q},
          {1'b0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0});
    apply({32'h7F80_0001, 32'h8000_0000, 32'hBF80_0000, 32'h7F80_0000}, 2'b10, 1'b1, 1'b1, 3'd3, 5'd0, 5'd0);
    check("R8 LE swap", {undef_q, mask_q},
          {1'b0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0});
    apply({32'h7F80_0001, 32'h8000_0000, 32'hBF80_0000, 32'h7F80_0000}, 2'b10, 1'b1, 1'b1, 3'd4, 5'd0, 5'd0);
    check("R8 LT swap", {undef_q, mask_q},
          {1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0});

    // R9 half mode drops upper lanes even when they would be true
    apply({64'h0, 64'h1}, 2'b01, 1'b0, 1'b0, 3'd0, 5'd0, 5'd0);
    check("R9 upper half zero", {undef_q, mask_q}, {1'b0, 64'h0, 48'hFFFF_FFFF_FFFF, 16'h0});

    // R1 reset mid-stream
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears after traffic", {undef_q, mask_q}, 129'h0);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule